// File: doc/BRIEF.md
# Linkable Breakpoint Comparator Bank

This block holds a small bank of breakpoint pairs. Each pair has a 32-bit value register and a control register. Software reaches both through a plain register bus: a write strobe with an address and data, and a read port that decodes the address combinationally. On every fetch strobe, each enabled pair tests its value against one of two inputs, selected by its meaning field. The first input is the word address of the instruction being fetched. The second is the current context ID. A pair can be set to a plain match, a mismatch (the inverse of an address match) or a context ID match.

An address pair can also be linked to a second pair. A linked pair fires only when its own address condition holds and, in the same cycle, the partner pair is enabled, is set to the linked context ID mode, and matches the context ID. Only the pairs with index `CTX_FIRST` and above have a context ID comparator. The block returns one registered event per fetch strobe, together with the set of pairs that fired.

The fetch input has no back-pressure. There is no ready signal, the block takes a fetch strobe in every cycle it is asserted, and each strobe gives exactly one result, registered one cycle later. Register writes are also accepted in every cycle.

Top module: `bkpt_bank`

## Requirements
- R1: After reset, every value and control register reads zero and `bkpt_event` and `bkpt_hits` are low.
- R2: Control register layout. Bit 0 is the enable, bits [19:16] hold the link target and bits [22:20] hold the meaning. These fields read back as written. Every other bit, including the mask field at [28:24], reads zero and ignores writes.
- R3: On pairs below `CTX_FIRST`, control bit 21 always reads zero. A write of meaning 010 or 011 to such a pair is therefore stored as 000 or 001.
- R4: A pair whose enable bit is 0 never fires and never satisfies a link from another pair.
- R5: Meaning 000 fires when bits [31:2] of the fetch address equal bits [31:2] of the value register. Address bits [1:0] are ignored.
- R6: Meaning 100 fires when bits [31:2] of the fetch address differ from bits [31:2] of the value register.
- R7: Meaning 010 fires when the context ID input equals the full 32-bit value register.
- R8: Meaning 001 (linked match) and meaning 101 (linked mismatch) fire only when two things hold: the pair's own address condition, and a partner named by the link field that is enabled, in meaning 011, and matching the context ID.
- R9: A linked pair never fires in three cases: its link field names itself, names a pair in any meaning other than 011, or names an index at or beyond `NUM_PAIRS`.
- R10: Meaning 011 never fires on its own, and the reserved meanings 110 and 111 never fire.
- R11: `bkpt_event` and `bkpt_hits` update on the clock edge that samples `fetch_valid` high and show the result one cycle after the strobe. A cycle without a strobe gives no event and all-zero hits. `bkpt_event` is high exactly when any bit of `bkpt_hits` is high.
- R12: A register write and a fetch strobe in the same cycle are both taken. The fetch is compared against the register contents from before the write.
- R13: The value register stores and reads back all 32 bits. Addresses `2*p` (value) and `2*p+1` (control) select pair p. Addresses naming a pair at or beyond `NUM_PAIRS` read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: bit 0 selects control (1) or value (0), upper bits give the pair |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| fetch_valid | input | 1 | Fetch strobe, one per retired fetch |
| fetch_addr | input | 32 | Instruction address of the fetch |
| ctx_id | input | 32 | Current context ID |
| bkpt_event | output | 1 | Registered breakpoint event |
| bkpt_hits | output | NUM_PAIRS | Registered per-pair hit flags |

## Verification
Two operations can land in the same cycle: a register write and a fetch comparison. This happens when a value register is rewritten in the very cycle a fetch strobe presents the old matching address. The bench drives both at once. It expects the result to follow the old value, and then checks that the next strobe follows the new value. A second overlap is inside the comparison itself, between a linked pair and its context ID partner. The bench checks this by changing the partner's enable, its mode, and the link target one at a time, and confirming that the linked pair fires only when all of them are valid.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [2:0] MEAN_ADDR     = 3'b000;
  localparam logic [2:0] MEAN_ADDR_LNK = 3'b001;
  localparam logic [2:0] MEAN_CTX      = 3'b010;
  localparam logic [2:0] MEAN_CTX_LNK  = 3'b011;
  localparam logic [2:0] MEAN_MIS      = 3'b100;
  localparam logic [2:0] MEAN_MIS_LNK  = 3'b101;

  typedef struct packed {
    logic              en;
    logic [2:0]        mean;
    logic [3:0]        link;
    logic [WORD_W-1:0] value;
  } pair_cfg_t;

  function automatic logic [WORD_W-1:0] pack_ctrl(input pair_cfg_t c);
    return {9'b0, c.mean, c.link, 15'b0, c.en};
  endfunction

endpackage

// File: rtl/bkpt_pair_regs.sv
module bkpt_pair_regs
  import bkpt_pkg::*;
#(
  parameter bit HAS_CTX = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_value,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  output pair_cfg_t         cfg
);

  logic ctx_bit;

  generate
    if (HAS_CTX) begin : g_ctx
      assign ctx_bit = wdata[21];
    end else begin : g_noctx
      assign ctx_bit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_value) cfg.value <= wdata;
      if (wr_ctrl) begin
        cfg.en   <= wdata[0];
        cfg.link <= wdata[19:16];
        cfg.mean <= {wdata[22], ctx_bit, wdata[20]};
      end
    end
  end

  generate
    if (!HAS_CTX) begin : g_chk
      // R3: a pair without a context comparator never holds a context meaning
      a_r3_no_ctx_mean: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !cfg.mean[1]);
    end
  endgenerate

endmodule

// File: rtl/bkpt_pair_cmp.sv
module bkpt_pair_cmp
  import bkpt_pkg::*;
(
  input  pair_cfg_t         cfg,
  input  logic [WORD_W-1:0] fetch_addr,
  input  logic [WORD_W-1:0] ctx_id,
  output logic              solo_hit,
  output logic              link_cand,
  output logic              partner_ok
);

  logic addr_eq;
  logic ctx_eq;
  logic cond;

  assign addr_eq = (fetch_addr[WORD_W-1:2] == cfg.value[WORD_W-1:2]);
  assign ctx_eq  = (ctx_id == cfg.value);

  always_comb begin
    unique case (cfg.mean)
      MEAN_ADDR, MEAN_ADDR_LNK: cond = addr_eq;
      MEAN_MIS,  MEAN_MIS_LNK:  cond = !addr_eq;
      MEAN_CTX:                 cond = ctx_eq;
      default:                  cond = 1'b0;
    endcase
  end

  assign solo_hit   = cfg.en & cond & !cfg.mean[0];
  assign link_cand  = cfg.en & cond & cfg.mean[0];
  assign partner_ok = cfg.en & (cfg.mean == MEAN_CTX_LNK) & ctx_eq;

endmodule

// File: rtl/bkpt_link_resolve.sv
module bkpt_link_resolve
  import bkpt_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] solo_hit,
  input  logic [NUM_PAIRS-1:0] link_cand,
  input  logic [NUM_PAIRS-1:0] partner_ok,
  input  logic [3:0]           link_tgt [NUM_PAIRS],
  output logic [NUM_PAIRS-1:0] hit
);

  always_comb begin
    for (int i = 0; i < NUM_PAIRS; i++) begin
      logic ok;
      ok = 1'b0;
      for (int j = 0; j < NUM_PAIRS; j++) begin
        if ((link_tgt[i] == 4'(j)) && (j != i)) ok = partner_ok[j];
      end
      hit[i] = solo_hit[i] | (link_cand[i] & ok);
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PAIRS; gi++) begin : g_chk
      // R8: a hit always has its own condition behind it
      a_r8_own_cond: assert property (@(posedge clk) disable iff (!rst_n)
        hit[gi] |-> (solo_hit[gi] | link_cand[gi]));
      // R9: a self-targeted link never fires
      a_r9_self_link: assert property (@(posedge clk) disable iff (!rst_n)
        (link_tgt[gi] == 4'(gi)) && !solo_hit[gi] |-> !hit[gi]);
    end
  endgenerate

endmodule

// File: rtl/bkpt_bank.sv
module bkpt_bank
  import bkpt_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 6,
  parameter int unsigned CTX_FIRST = 4,
  parameter int unsigned ADDR_W    = $clog2(NUM_PAIRS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 fetch_valid,
  input  logic [31:0]          fetch_addr,
  input  logic [31:0]          ctx_id,
  output logic                 bkpt_event,
  output logic [NUM_PAIRS-1:0] bkpt_hits
);

  localparam int unsigned IDX_W = ADDR_W - 1;

  pair_cfg_t            cfg_a [NUM_PAIRS];
  logic [3:0]           link_a [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] solo_hit;
  logic [NUM_PAIRS-1:0] link_cand;
  logic [NUM_PAIRS-1:0] partner_ok;
  logic [NUM_PAIRS-1:0] hit;
  logic [IDX_W-1:0]     sel_idx;

  assign sel_idx = reg_addr[ADDR_W-1:1];

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PAIRS; gp++) begin : g_pair
      logic wr_hit;
      assign wr_hit = reg_we && (sel_idx == IDX_W'(gp));

      bkpt_pair_regs #(.HAS_CTX(gp >= CTX_FIRST)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_value (wr_hit & !reg_addr[0]),
        .wr_ctrl  (wr_hit & reg_addr[0]),
        .wdata    (reg_wdata),
        .cfg      (cfg_a[gp])
      );

      bkpt_pair_cmp i_cmp (
        .cfg        (cfg_a[gp]),
        .fetch_addr (fetch_addr),
        .ctx_id     (ctx_id),
        .solo_hit   (solo_hit[gp]),
        .link_cand  (link_cand[gp]),
        .partner_ok (partner_ok[gp])
      );

      assign link_a[gp] = cfg_a[gp].link;

      // R4: a disabled pair never fires
      a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_a[gp].en |-> !hit[gp]);
      // R10: linked-context and reserved meanings never fire themselves
      a_r10_no_self_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_a[gp].mean == MEAN_CTX_LNK || cfg_a[gp].mean[2:1] == 2'b11) |-> !hit[gp]);
    end
  endgenerate

  bkpt_link_resolve #(.NUM_PAIRS(NUM_PAIRS)) i_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .solo_hit   (solo_hit),
    .link_cand  (link_cand),
    .partner_ok (partner_ok),
    .link_tgt   (link_a),
    .hit        (hit)
  );

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (sel_idx == IDX_W'(p))
        reg_rdata = reg_addr[0] ? pack_ctrl(cfg_a[p]) : cfg_a[p].value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bkpt_event <= 1'b0;
      bkpt_hits  <= '0;
    end else begin
      bkpt_event <= fetch_valid & (|hit);
      bkpt_hits  <= fetch_valid ? hit : '0;
    end
  end

  // R11: an event follows a strobe and agrees with the hit flags
  a_r11_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !bkpt_event && (bkpt_hits == '0));
  a_r11_event_or: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_event == (|bkpt_hits));
  // R2: the reserved bits of a control read stay zero
  a_r2_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[0] |-> (reg_rdata[31:23] == '0) && (reg_rdata[15:1] == '0));

endmodule

// File: tb/test_bkpt_bank.sv
module test_bkpt_bank;

  localparam int NP = 6;
  localparam int AW = 4;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          fetch_valid = 1'b0;
  logic [31:0]   fetch_addr = '0;
  logic [31:0]   ctx_id = '0;
  logic          bkpt_event;
  logic [NP-1:0] bkpt_hits;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bkpt_bank #(.NUM_PAIRS(NP), .CTX_FIRST(4)) i_bkpt_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .ctx_id(ctx_id), .bkpt_event(bkpt_event),
    .bkpt_hits(bkpt_hits)
  );

  // {valid, fetch address, context ID, expected hits}
  // Setup: p0 addr 0x1000; p1 linked mismatch 0x2000 -> p4; p2 linked 0x3000 -> p5 (010);
  // p3 linked 0x4000 -> itself; p4 linked ctx 0xCAFE; p5 ctx 0x77.
  localparam logic [70:0] VECS [NV] = '{
    {1'b1, 32'h0000_1000, 32'h0000_0000, 6'h01},  // R5 exact word
    {1'b1, 32'h0000_1003, 32'h0000_0000, 6'h01},  // R5 low bits ignored
    {1'b1, 32'h0000_1004, 32'h0000_0000, 6'h00},  // R5 next word
    {1'b1, 32'h0000_1000, 32'h0000_CAFE, 6'h03},  // R6 R8 linked mismatch, R10 p4 silent
    {1'b1, 32'h0000_2000, 32'h0000_CAFE, 6'h00},  // R6 equal word, no mismatch
    {1'b1, 32'h0000_2002, 32'h0000_CAFE, 6'h00},  // R6 same word
    {1'b1, 32'h0000_3000, 32'h0000_0077, 6'h20},  // R7 p5, R9 link to 010 pair
    {1'b1, 32'h0000_4000, 32'h0000_CAFE, 6'h02},  // R9 self link silent
    {1'b1, 32'h0000_5000, 32'h0000_0077, 6'h20},  // R7
    {1'b1, 32'h0000_1000, 32'h0000_0077, 6'h21},  // R5 R7 together
    {1'b0, 32'h0000_1000, 32'h0000_0077, 6'h00}   // R11 no strobe
  };

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    n_vec++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: addr %0d read %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_out(input logic [NP-1:0] exp, input string tag);
    n_vec++;
    if (bkpt_hits !== exp || bkpt_event !== (|exp)) begin
      n_bad++;
      $display("FAIL %s: hits %b event %b expected hits %b event %b",
               tag, bkpt_hits, bkpt_event, exp, |exp);
    end
  endtask

  task automatic fetch_chk(input logic v, input logic [31:0] a, input logic [31:0] c,
                           input logic [NP-1:0] exp, input string tag);
    @(negedge clk);
    fetch_valid = v; fetch_addr = a; ctx_id = c;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk_out(exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(1, 32'h0, "R1 ctrl p0");
    rd_chk(10, 32'h0, "R1 value p5");
    chk_out('0, "R1 outputs");

    wr(0, 32'h0000_1000);  wr(1, 32'h0000_0001);
    wr(2, 32'h0000_2000);  wr(3, 32'h0054_0001);
    wr(4, 32'h0000_3000);  wr(5, 32'h0015_0001);
    wr(6, 32'h0000_4000);  wr(7, 32'h0013_0001);
    wr(8, 32'h0000_CAFE);  wr(9, 32'h0030_0001);
    wr(10, 32'h0000_0077); wr(11, 32'h0020_0001);
    rd_chk(9, 32'h0030_0001, "R2 linked ctx readback");

    for (int k = 0; k < NV; k++) begin
      fetch_chk(VECS[k][70], VECS[k][69:38], VECS[k][37:6], VECS[k][5:0],
                $sformatf("table vec %0d", k));
    end

    // R12 write and fetch in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(0); reg_wdata = 32'h0000_8000;
    fetch_valid = 1'b1; fetch_addr = 32'h0000_1000; ctx_id = 32'h0;
    @(negedge clk);
    reg_we = 1'b0; fetch_valid = 1'b0;
    chk_out(6'h01, "R12 old value used");
    fetch_chk(1'b1, 32'h0000_1000, 32'h0, 6'h00, "R12 old address gone");
    fetch_chk(1'b1, 32'h0000_8000, 32'h0, 6'h01, "R12 new address");

    // R8 relink p2 to the linked ctx pair p4
    wr(5, 32'h0014_0001);
    fetch_chk(1'b1, 32'h0000_3000, 32'h0000_CAFE, 6'h06, "R8 linked match");
    fetch_chk(1'b1, 32'h0000_3000, 32'h0000_CAFF, 6'h00, "R8 partner ctx differs");
    // R9 link target out of range
    wr(5, 32'h0019_0001);
    fetch_chk(1'b1, 32'h0000_3000, 32'h0000_CAFE, 6'h02, "R9 link out of range");
    // R4 disabled partner does not satisfy link
    wr(9, 32'h0030_0000);
    fetch_chk(1'b1, 32'h0000_3000, 32'h0000_CAFE, 6'h00, "R4 disabled partner");
    // R10 reserved meaning on a context pair
    wr(11, 32'h0060_0001);
    fetch_chk(1'b1, 32'h0000_0000, 32'h0000_0077, 6'h00, "R10 reserved meaning");
    // R2 field masking
    wr(11, 32'hFFFF_FFFF);
    rd_chk(11, 32'h007F_0001, "R2 reserved bits zero");
    // R3 no context bit on low pairs
    wr(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'h005F_0001, "R3 bit21 zero");
    wr(1, 32'h0020_0001);
    rd_chk(1, 32'h0000_0001, "R3 ctx meaning becomes address");
    // R13 full-width value and out-of-range pair
    wr(6, 32'hDEAD_BEEF);
    rd_chk(6, 32'hDEAD_BEEF, "R13 value readback");
    wr(12, 32'h1234_5678);
    rd_chk(12, 32'h0, "R13 pair beyond bank");
    // R4 disabled address pair
    wr(1, 32'h0000_0000);
    fetch_chk(1'b1, 32'h0000_8000, 32'h0, 6'h00, "R4 disabled pair");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule